// File: doc/BRIEF.md
# Core Power State Controller

This block moves a processor core between three power states and one transitional state. In the active state every functional-unit clock runs and no status is shown. A halt request first waits for the bus to go quiet and for the store and push buffers to empty. Once both are done, the core enters the halted state. In that state most unit clocks are gated and the halted status is raised. A stop request while halted takes the core down to the stopped state. There, every unit clock is off and only the time-base clock may keep running. The controller itself stays clocked in every state.

Exit runs in the reverse order: stopped to halted to active. Leaving the stopped state also requires a flag saying the main clock is valid again. General wake events are always honoured. A time-base interrupt counts as a wake event only when the time base runs from its independent clock source. The time-base disable input gates the time-base clock only while the core is stopped. Wake events are levels, held by their source until the core has serviced them.

Top module: `core_pwr_seq`

## Requirements
- R1: While reset is low and after its release, the block is in the active state: `unit_clk_en` is all ones, `tb_clk_en` is 1, and `halted` and `stopped` are 0.
- R2: In the active state, when `halt_req` is 1 and both `bus_idle` and `bufs_empty` are 1 at a clock edge, `halted` is 1 after that edge. `unit_clk_en` then equals the `HALT_KEEP` mask (default 8'h01, bit 0 kept running).
- R3: If `halt_req` is 1 while `bus_idle` or `bufs_empty` is 0, the block drains. `halted` and `stopped` stay 0 and `unit_clk_en` stays all ones. `halted` becomes 1 after the first edge at which both completion inputs are 1.
- R4: If `halt_req` drops to 0 while draining, the block returns to the active state after that edge.
- R5: `stopped` becomes 1 only from the halted state, after an edge where `stop_req` is 1, `halt_req` is 1 and no qualified wake is present. `halted` is 0 while `stopped` is 1, and `unit_clk_en` is 0. `stop_req` has no effect in the active state.
- R6: `tb_clk_en` is 0 only while `stopped` is 1 and `tb_disable` is 1. In every other case `tb_clk_en` is 1, including the halted state with `tb_disable` at 1.
- R7: `tb_irq` acts as a wake event only when `tb_ext_clk` is 1. With `tb_ext_clk` at 0, it changes no state.
- R8: From the stopped state, the block returns to halted only at an edge where `clk_valid` is 1 and at least one of these holds: `stop_req` is 0, `halt_req` is 0, or a qualified wake is present. While `clk_valid` is 0 it stays stopped.
- R9: From the halted state, the block returns to active after an edge where `halt_req` is 0 or a qualified wake is present. Any bit of `wake_evt` qualifies. A wake takes priority over `stop_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, never gated by this block |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_req | input | 1 | Request to halt the core (level) |
| stop_req | input | 1 | Request to go on from halted to stopped (level) |
| tb_disable | input | 1 | Gate the time-base clock while stopped |
| tb_ext_clk | input | 1 | Time base runs from the independent clock source |
| clk_valid | input | 1 | Main core clock is running and usable |
| bus_idle | input | 1 | No bus transaction outstanding |
| bufs_empty | input | 1 | Store and push buffers flushed |
| wake_evt | input | NUM_WAKE | General wake events (levels) |
| tb_irq | input | 1 | Time-base derived interrupt |
| unit_clk_en | output | NUM_UNITS | Clock enables of the functional units |
| tb_clk_en | output | 1 | Clock enable of the time-base unit |
| halted | output | 1 | Core is in the halted state |
| stopped | output | 1 | Core is in the stopped state |

## Verification
The assertions assume that every request and handshake input is synchronous to `clk`. They also assume that `wake_evt` and `tb_irq` are levels, held until the state they target has been reached. The bench changes inputs only on the falling edge and holds each value for at least one full cycle. It keeps wake levels up across the two steps from stopped to active, and it drops the completion inputs only while a halt is pending. This keeps the bench within those assumptions.

// File: rtl/pwr_pkg.sv
// Shared types of the core power state controller.
// Assumes: nothing beyond a 2-bit state encoding.
package pwr_pkg;
    typedef enum logic [1:0] {
        PS_ACTIVE  = 2'd0,
        PS_DRAIN   = 2'd1,
        PS_HALTED  = 2'd2,
        PS_STOPPED = 2'd3
    } pwr_state_e;
endpackage

// File: rtl/pwr_wake_qual.sv
// Merges the wake sources into a single qualified wake level.
// A time-base interrupt only counts when the time base runs on its
// independent clock. Assumes all sources are synchronous levels.
module pwr_wake_qual #(
    parameter int NUM_WAKE = 4
) (
    input  logic [NUM_WAKE-1:0] wake_evt,
    input  logic                tb_irq,
    input  logic                tb_ext_clk,
    output logic                wake_ok
);
    logic tb_wake;

    // Time-base interrupt is trusted only from the independent source.
    always_comb begin
        tb_wake = tb_irq & tb_ext_clk;
    end

    // Any general event or a qualified time-base interrupt wakes the core.
    always_comb begin
        wake_ok = (|wake_evt) | tb_wake;
    end
endmodule

// File: rtl/pwr_state_fsm.sv
// Power state sequencer: active -> drain -> halted -> stopped and back.
// Assumes synchronous inputs and a free-running controller clock.
module pwr_state_fsm
    import pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_req,
    input  logic       stop_req,
    input  logic       clk_valid,
    input  logic       bus_idle,
    input  logic       bufs_empty,
    input  logic       wake_ok,
    output pwr_state_e state
);
    pwr_state_e state_nxt;
    logic       drained;

    // Drain is complete when the bus and both buffers are quiet.
    always_comb begin
        drained = bus_idle & bufs_empty;
    end

    // Next-state decision for each power state.
    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_ACTIVE: begin
                if (halt_req) state_nxt = drained ? PS_HALTED : PS_DRAIN;
            end
            PS_DRAIN: begin
                if (!halt_req)    state_nxt = PS_ACTIVE;
                else if (drained) state_nxt = PS_HALTED;
            end
            PS_HALTED: begin
                if (!halt_req || wake_ok) state_nxt = PS_ACTIVE;
                else if (stop_req)        state_nxt = PS_STOPPED;
            end
            PS_STOPPED: begin
                if (clk_valid && (!stop_req || !halt_req || wake_ok))
                    state_nxt = PS_HALTED;
            end
            default: state_nxt = PS_ACTIVE;
        endcase
    end

    // State register with synchronous active-low reset to active.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= PS_ACTIVE;
        else        state <= state_nxt;
    end
endmodule

// File: rtl/pwr_clk_ctrl.sv
// Decodes the power state into clock enables and status outputs.
// HALT_KEEP selects the units that keep their clock in the halted state.
// Assumes the state input comes straight from a register.
module pwr_clk_ctrl
    import pwr_pkg::*;
#(
    parameter int                   NUM_UNITS = 8,
    parameter logic [NUM_UNITS-1:0] HALT_KEEP = 8'h01
) (
    input  pwr_state_e           state,
    input  logic                 tb_disable,
    output logic [NUM_UNITS-1:0] unit_clk_en,
    output logic                 tb_clk_en,
    output logic                 halted,
    output logic                 stopped
);
    // Per-unit enable: each bit chooses its halted behaviour from the mask.
    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        always_comb begin
            unique case (state)
                PS_HALTED:  unit_clk_en[u] = HALT_KEEP[u];
                PS_STOPPED: unit_clk_en[u] = 1'b0;
                default:    unit_clk_en[u] = 1'b1;
            endcase
        end
    end

    // Status flags and the time-base gate, honoured only when stopped.
    always_comb begin
        halted    = (state == PS_HALTED);
        stopped   = (state == PS_STOPPED);
        tb_clk_en = !((state == PS_STOPPED) && tb_disable);
    end
endmodule

// File: rtl/core_pwr_seq.sv
// Top of the core power state controller. Wires wake qualification,
// the state sequencer and the clock-enable decoder together.
// Assumes all inputs are synchronous to clk; wakes are held levels.
module core_pwr_seq
    import pwr_pkg::*;
#(
    parameter int                   NUM_UNITS = 8,
    parameter int                   NUM_WAKE  = 4,
    parameter logic [NUM_UNITS-1:0] HALT_KEEP = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 halt_req,
    input  logic                 stop_req,
    input  logic                 tb_disable,
    input  logic                 tb_ext_clk,
    input  logic                 clk_valid,
    input  logic                 bus_idle,
    input  logic                 bufs_empty,
    input  logic [NUM_WAKE-1:0]  wake_evt,
    input  logic                 tb_irq,
    output logic [NUM_UNITS-1:0] unit_clk_en,
    output logic                 tb_clk_en,
    output logic                 halted,
    output logic                 stopped
);
    logic       wake_ok;
    pwr_state_e state;

    pwr_wake_qual #(.NUM_WAKE(NUM_WAKE)) u_wake (
        .wake_evt   (wake_evt),
        .tb_irq     (tb_irq),
        .tb_ext_clk (tb_ext_clk),
        .wake_ok    (wake_ok)
    );

    pwr_state_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_req   (halt_req),
        .stop_req   (stop_req),
        .clk_valid  (clk_valid),
        .bus_idle   (bus_idle),
        .bufs_empty (bufs_empty),
        .wake_ok    (wake_ok),
        .state      (state)
    );

    pwr_clk_ctrl #(.NUM_UNITS(NUM_UNITS), .HALT_KEEP(HALT_KEEP)) u_clk (
        .state       (state),
        .tb_disable  (tb_disable),
        .unit_clk_en (unit_clk_en),
        .tb_clk_en   (tb_clk_en),
        .halted      (halted),
        .stopped     (stopped)
    );
endmodule

// File: rtl/core_pwr_seq_chk.sv
// Port-level checker for the core power state controller, bound to the top.
// Assumes reset is held low from time zero for at least one edge.
module core_pwr_seq_chk #(
    parameter int NUM_UNITS = 8,
    parameter int NUM_WAKE  = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 halt_req,
    input logic                 stop_req,
    input logic                 tb_disable,
    input logic                 tb_ext_clk,
    input logic                 clk_valid,
    input logic                 bus_idle,
    input logic                 bufs_empty,
    input logic [NUM_WAKE-1:0]  wake_evt,
    input logic                 tb_irq,
    input logic [NUM_UNITS-1:0] unit_clk_en,
    input logic                 tb_clk_en,
    input logic                 halted,
    input logic                 stopped
);
    AST_STATUS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(halted && stopped)); // R5
    AST_STOP_VIA_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stopped) |-> $past(halted) && $past(stop_req)); // R5
    AST_HALT_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(halted) && !$past(stopped)) |-> $past(bus_idle && bufs_empty && halt_req)); // R3
    AST_STOP_EXIT_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stopped) |-> $past(clk_valid) && halted); // R8
    AST_HALT_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(halted) && !stopped) |->
            $past(!halt_req || (|wake_evt) || (tb_irq && tb_ext_clk))); // R7
    AST_TB_GATE_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        !tb_clk_en |-> stopped && tb_disable); // R6
    AST_RUNNING_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (!halted && !stopped) |-> (&unit_clk_en)); // R3
endmodule

bind core_pwr_seq core_pwr_seq_chk #(.NUM_UNITS(NUM_UNITS), .NUM_WAKE(NUM_WAKE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .stop_req    (stop_req),
    .tb_disable  (tb_disable),
    .tb_ext_clk  (tb_ext_clk),
    .clk_valid   (clk_valid),
    .bus_idle    (bus_idle),
    .bufs_empty  (bufs_empty),
    .wake_evt    (wake_evt),
    .tb_irq      (tb_irq),
    .unit_clk_en (unit_clk_en),
    .tb_clk_en   (tb_clk_en),
    .halted      (halted),
    .stopped     (stopped)
);

// File: tb/test_core_pwr_seq.sv
// Scoreboard bench: the driver pushes the expected outputs per cycle,
// the monitor pops and compares them just after each rising edge.
module test_core_pwr_seq;
    localparam int          CLK_PERIOD = 10;
    localparam int          NU = 8;
    localparam int          NW = 4;
    localparam logic [NU-1:0] KEEP = 8'h01;

    typedef struct {
        logic          halted;
        logic          stopped;
        logic [NU-1:0] units;
        logic          tb_en;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hr = 0, sr = 0, tbd = 0, ext = 0, cv = 1, bi = 1, be = 1, tbi = 0;
    logic [NW-1:0] wk = '0;
    logic [NU-1:0] unit_clk_en;
    logic tb_clk_en, halted, stopped;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 0;

    core_pwr_seq #(.NUM_UNITS(NU), .NUM_WAKE(NW), .HALT_KEEP(KEEP)) i_core_pwr_seq (
        .clk(clk), .rst_n(rst_n), .halt_req(hr), .stop_req(sr),
        .tb_disable(tbd), .tb_ext_clk(ext), .clk_valid(cv),
        .bus_idle(bi), .bufs_empty(be), .wake_evt(wk), .tb_irq(tbi),
        .unit_clk_en(unit_clk_en), .tb_clk_en(tb_clk_en),
        .halted(halted), .stopped(stopped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Driver: push the outputs expected after the coming edge, then wait a cycle.
    // st: "A" active, "D" draining, "H" halted, "S" stopped.
    task automatic step(input string st, input string tag);
        exp_t e;
        e.halted  = (st == "H");
        e.stopped = (st == "S");
        e.units   = (st == "H") ? KEEP : (st == "S") ? '0 : '1;
        e.tb_en   = !((st == "S") && tbd);
        e.tag     = tag;
        sb_q.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: compare outputs against the scoreboard after each edge.
    always @(posedge clk) begin
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (halted !== e.halted || stopped !== e.stopped ||
                unit_clk_en !== e.units || tb_clk_en !== e.tb_en) begin
                n_fail++;
                $display("FAIL %s: got h=%b s=%b u=%h tb=%b, expected h=%b s=%b u=%h tb=%b",
                         e.tag, halted, stopped, unit_clk_en, tb_clk_en,
                         e.halted, e.stopped, e.units, e.tb_en);
            end
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step("A", "R1 in reset"); step("A", "R1 in reset");
        rst_n = 1;
        step("A", "R1 after reset");
        sr = 1;            step("A", "R5 stop ignored in active");
        sr = 0;
        hr = 1; bi = 0;    step("D", "R3 drain bus busy"); step("D", "R3 drain held");
        bi = 1; be = 0;    step("D", "R3 drain buffers busy");
        be = 1;            step("H", "R2 R3 halted after drain");
        hr = 0;            step("A", "R9 halt released");
        hr = 1; bi = 0;    step("D", "R4 drain entered");
        hr = 0;            step("A", "R4 drain aborted");
        bi = 1; hr = 1;    step("H", "R2 halt when idle");
        tbi = 1;           step("H", "R7 tb irq ignored on main clock");
        tbi = 0; wk = 4'b0100; step("A", "R9 wake event");
        wk = 0; hr = 1;    step("H", "R2 halt again");
        tbd = 1;           step("H", "R6 tb runs while halted");
        tbd = 0; sr = 1;   step("S", "R5 stopped");
        tbd = 1;           step("S", "R6 tb gated when stopped");
        tbd = 0;           step("S", "R6 tb ungated");
        cv = 0; sr = 0;    step("S", "R8 held without clock valid");
        cv = 1;            step("H", "R8 exit to halted");
        step("H", "R8 halted stays with halt req");
        sr = 1;            step("S", "R5 stop again");
        tbi = 1;           step("S", "R7 tb irq ignored when stopped");
        ext = 1;           step("H", "R7 tb irq qualified");
        step("A", "R9 wake beats stop");
        tbi = 0; ext = 0;  step("H", "R2 halt with stop held");
        step("S", "R5 stop from halted");
        cv = 0; wk = 4'b0001; step("S", "R8 wake waits for clock");
        cv = 1;            step("H", "R8 wake exit");
        step("A", "R9 wake to active");
        wk = 0; hr = 0; sr = 0; step("A", "R1 idle active");
        done = 1;
        #1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule